// File: doc/BRIEF.md
# Timer Capture Channel with Software Trigger

This block is one capture channel beside a free-running up-counter. The counter runs on its own timer clock, which need not match the system clock. A two-bit source select gives the channel its input. That input is either an external pin or a fixed logic level. A two-bit edge mode then decides which transitions of the chosen input cause a capture: none, rising, falling or both.

Software can trigger a capture without any pin activity. It sets the select to a fixed level and flips the level bit; every flip is an edge on the capture input. Two capture styles exist:

- **Immediate.** The counter value is taken at once in the system clock domain, through a Gray-coded copy of the counter.
- **Timer-aligned.** The trigger is held as a pending request and carried into the timer domain. The copy is made there on a falling timer-clock edge, while the counter (which steps on rising edges) is steady. A pending request is always completed, even if the input has already returned to its earlier level.

Each completed capture raises a capture flag. A capture that lands while that flag is still up also raises an overflow flag.

Top module: `tcap_channel`

## Requirements
- R1: While `rst` is high, and after it is released until the first capture, `cap_value` is 0 and both flags are 0. `tmr_count` is 0 while the reset is held.
- R2: `tmr_count` increases by exactly one on every rising edge of `tclk` and never changes on a falling edge.
- R3: Source select encoding:
  - `in_sel` = 2'b00 or 2'b01 uses the external pin `cap_pin`.
  - 2'b10 gives a constant 0.
  - 2'b11 gives a constant 1.
  - With a constant selected, activity on `cap_pin` has no effect.
- R4: Edge mode encoding for `edge_mode`: 2'b00 means no capture, 2'b01 rising edges, 2'b10 falling edges and 2'b11 both edges. Each qualifying edge of the selected input gives exactly one capture when triggers are spaced apart.
- R5: With `sync_mode` = 0, the capture completes within 4 system clock cycles of the input change. The value comes from a Gray copy of the counter that changes by at most one bit per timer tick, so it is never torn. The value lies between the counter value at the trigger minus a few ticks of synchronizer lag and the current counter value.
- R6: With `sync_mode` = 1, no capture happens while `tclk` is stopped. The counter is copied on the third falling `tclk` edge after the trigger, so the captured value equals `tmr_count` as it stood just before that falling edge.
- R7: In timer-aligned mode, a trigger pulse that has already ended before any timer edge still produces its capture.
- R8: In timer-aligned mode, further triggers that arrive while a request is still pending merge into it and produce no extra capture.
- R9: Every completed capture sets `cap_flag`. A one-cycle pulse on `clr_cap_flag` clears it. A capture in the same cycle as the clear wins.
- R10: `ovf_flag` is set when a capture completes while `cap_flag` is already set and is not being cleared in that cycle. A pulse on `clr_ovf_flag` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system clock domain |
| tclk | input | 1 | Timer clock, asynchronous to `clk` |
| cap_pin | input | 1 | External capture input |
| in_sel | input | 2 | Capture source select |
| edge_mode | input | 2 | Edges that trigger a capture |
| sync_mode | input | 1 | 1 = capture aligned to falling `tclk` edge |
| clr_cap_flag | input | 1 | Pulse to clear `cap_flag` |
| clr_ovf_flag | input | 1 | Pulse to clear `ovf_flag` |
| cap_value | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | A capture has completed |
| ovf_flag | output | 1 | A capture landed on an unread value |
| tmr_count | output | CNT_W | Free-running counter, timer domain |

## Verification
On every cycle, the assertions check four things:
- the Gray copy steps by at most one bit;
- the timer-side capture register stays still whenever no request is pending;
- triggers during a pending request do not re-toggle the request;
- the flags follow completed captures.

Whether the value lands at the third falling edge can only be shown by the bench's scenarios. It drives the timer clock by hand to show this, and also shows that a short pulse is still captured. The same holds for whether each software flip yields exactly one capture at timer clocks slower than, equal to and faster than the system clock.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    EM_OFF  = 2'b00,
    EM_RISE = 2'b01,
    EM_FALL = 2'b10,
    EM_BOTH = 2'b11
  } edge_mode_e;

  localparam logic [1:0] SEL_LOW  = 2'b10;
  localparam logic [1:0] SEL_HIGH = 2'b11;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i+1] <= '0;
      else     chain[i+1] <= chain[i];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/tcap_timer.sv
module tcap_timer #(
  parameter int CNT_W      = 16,
  parameter int RST_STAGES = 2
) (
  input  logic             tclk,
  input  logic             rst,
  output logic             rst_t,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] gray
);
  logic [CNT_W-1:0] cnt_nxt;

  // reset carried into the timer domain
  tcap_sync #(.W(1), .STAGES(RST_STAGES)) u_rst_sync (
    .clk (tclk),
    .rst (1'b0),
    .d   (rst),
    .q   (rst_t)
  );

  assign cnt_nxt = count + 1'b1;

  always_ff @(posedge tclk) begin
    if (rst_t) begin
      count <= '0;
      gray  <= '0;
    end else begin
      count <= cnt_nxt;
      gray  <= cnt_nxt ^ (cnt_nxt >> 1);
    end
  end

  AST_GRAY_ONE_STEP: assert property (@(posedge tclk) disable iff (rst_t)
    $countones(gray ^ $past(gray)) <= 1); // R5
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge
  import tcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_pin,
  input  logic [1:0] in_sel,
  input  logic [1:0] edge_mode,
  output logic       hit
);
  logic       pin_s;
  logic       src;
  logic       lvl_q;
  logic       rise;
  logic       fall;
  edge_mode_e mode;

  tcap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk (clk),
    .rst (rst),
    .d   (cap_pin),
    .q   (pin_s)
  );

  always_comb begin
    case (in_sel)
      SEL_LOW:  src = 1'b0;
      SEL_HIGH: src = 1'b1;
      default:  src = pin_s;
    endcase
  end

  assign mode = edge_mode_e'(edge_mode);
  assign rise = src & ~lvl_q;
  assign fall = ~src & lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      hit   <= 1'b0;
    end else begin
      lvl_q <= src;
      case (mode)
        EM_RISE: hit <= rise;
        EM_FALL: hit <= fall;
        EM_BOTH: hit <= rise | fall;
        default: hit <= 1'b0;
      endcase
    end
  end

  AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(src) != $past(lvl_q))); // R4
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (edge_mode == 2'b00) |=> !hit); // R4
endmodule

// File: rtl/tcap_xfer.sv
module tcap_xfer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tclk,
  input  logic             rst_t,
  input  logic             req_hit,
  input  logic [CNT_W-1:0] count,
  output logic             done,
  output logic [CNT_W-1:0] value
);
  logic             req_q;
  logic             ack_s;
  logic             ack_d;
  logic             busy;
  logic             tclk_n;
  logic             req_s;
  logic             ack_t;
  logic [CNT_W-1:0] cap_t;

  // system clock side: toggle request, merged while pending
  assign busy = req_q ^ ack_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      ack_d <= 1'b0;
    end else begin
      if (req_hit && !busy) req_q <= ~req_q;
      ack_d <= ack_s;
    end
  end

  assign done  = ack_s ^ ack_d;
  assign value = cap_t;

  tcap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_t),
    .q   (ack_s)
  );

  // timer side: everything on the falling edge
  assign tclk_n = ~tclk;

  tcap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk (tclk_n),
    .rst (rst_t),
    .d   (req_q),
    .q   (req_s)
  );

  always_ff @(posedge tclk_n) begin
    if (rst_t) begin
      ack_t <= 1'b0;
      cap_t <= '0;
    end else if (req_s != ack_t) begin
      ack_t <= req_s;
      cap_t <= count;
    end
  end

  AST_CAPT_HOLD_IDLE: assert property (@(posedge tclk_n) disable iff (rst_t)
    (req_s == ack_t) |=> $stable(cap_t)); // R6
  AST_MERGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy |=> (req_q == $past(req_q))); // R8
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tclk,
  input  logic             cap_pin,
  input  logic [1:0]       in_sel,
  input  logic [1:0]       edge_mode,
  input  logic             sync_mode,
  input  logic             clr_cap_flag,
  input  logic             clr_ovf_flag,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             ovf_flag,
  output logic [CNT_W-1:0] tmr_count
);
  logic             rst_t;
  logic [CNT_W-1:0] gray_t;
  logic [CNT_W-1:0] gray_s;
  logic [CNT_W-1:0] gray_bin;
  logic             hit;
  logic             async_hit;
  logic             sync_done;
  logic [CNT_W-1:0] sync_val;
  logic             cap_load;
  logic [CNT_W-1:0] cap_next;

  tcap_timer #(.CNT_W(CNT_W), .RST_STAGES(SYNC_STAGES)) u_timer (
    .tclk  (tclk),
    .rst   (rst),
    .rst_t (rst_t),
    .count (tmr_count),
    .gray  (gray_t)
  );

  tcap_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_gray_sync (
    .clk (clk),
    .rst (rst),
    .d   (gray_t),
    .q   (gray_s)
  );

  always_comb begin
    gray_bin[CNT_W-1] = gray_s[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) gray_bin[i] = gray_bin[i+1] ^ gray_s[i];
  end

  tcap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .cap_pin   (cap_pin),
    .in_sel    (in_sel),
    .edge_mode (edge_mode),
    .hit       (hit)
  );

  tcap_xfer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk     (clk),
    .rst     (rst),
    .tclk    (tclk),
    .rst_t   (rst_t),
    .req_hit (hit & sync_mode),
    .count   (tmr_count),
    .done    (sync_done),
    .value   (sync_val)
  );

  assign async_hit = hit & ~sync_mode;
  assign cap_load  = async_hit | sync_done;
  assign cap_next  = async_hit ? gray_bin : sync_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (cap_load) cap_value <= cap_next;

      if (cap_load)          cap_flag <= 1'b1;
      else if (clr_cap_flag) cap_flag <= 1'b0;

      if (cap_load && cap_flag && !clr_cap_flag) ovf_flag <= 1'b1;
      else if (clr_ovf_flag)                      ovf_flag <= 1'b0;
    end
  end

  AST_FLAG_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    cap_load |=> cap_flag); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(cap_flag)); // R10
endmodule

// File: tb/sim_tcap_channel.sv
module sim_tcap_channel;
  localparam int W = 16;

  // vector: {mode[12:11], sync[10], tsel[9:8], ntog[7:4], exp[3:0]}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {2'b01, 1'b0, 2'd0, 4'd4, 4'd2},
    {2'b10, 1'b0, 2'd1, 4'd4, 4'd2},
    {2'b11, 1'b0, 2'd2, 4'd4, 4'd4},
    {2'b00, 1'b0, 2'd1, 4'd4, 4'd0},
    {2'b11, 1'b1, 2'd0, 4'd4, 4'd4},
    {2'b11, 1'b1, 2'd1, 4'd4, 4'd4},
    {2'b11, 1'b1, 2'd2, 4'd4, 4'd4},
    {2'b01, 1'b1, 2'd2, 4'd3, 4'd2}
  };

  logic         clk = 0;
  logic         rst = 1;
  logic         tclk = 1;
  logic         cap_pin = 0;
  logic [1:0]   in_sel = 2'b10;
  logic [1:0]   edge_mode = 2'b00;
  logic         sync_mode = 0;
  logic         clr_cap_flag = 0;
  logic         clr_ovf_flag = 0;
  logic [W-1:0] cap_value;
  logic         cap_flag;
  logic         ovf_flag;
  logic [W-1:0] tmr_count;

  int  thalf = 4;
  bit  trun  = 1;
  int  nchk  = 0;
  int  nfail = 0;
  bit  ended = 0;

  tcap_channel #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
    .clk          (clk),
    .rst          (rst),
    .tclk         (tclk),
    .cap_pin      (cap_pin),
    .in_sel       (in_sel),
    .edge_mode    (edge_mode),
    .sync_mode    (sync_mode),
    .clr_cap_flag (clr_cap_flag),
    .clr_ovf_flag (clr_ovf_flag),
    .cap_value    (cap_value),
    .cap_flag     (cap_flag),
    .ovf_flag     (ovf_flag),
    .tmr_count    (tmr_count)
  );

  initial forever #4 clk = ~clk;

  initial forever begin
    #(thalf);
    if (trun) tclk = ~tclk;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_cap();
    clr_cap_flag = 1; tick(1); clr_cap_flag = 0;
  endtask

  task automatic clr_ovf();
    clr_ovf_flag = 1; tick(1); clr_ovf_flag = 0;
  endtask

  // one falling then one rising timer edge, by hand
  task automatic tpulse();
    tclk = 0; tick(3);
    tclk = 1; tick(3);
  endtask

  task automatic stop_tclk();
    @(posedge tclk);
    trun = 0;
    tick(2);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int c0;
    int seen;
    int mode_v, sync_v, tsel_v, ntog_v, exp_v;

    // R1 reset state
    tick(20);
    check(tmr_count == 0, "R1 count in reset", tmr_count, 0);
    check(cap_value == 0 && !cap_flag && !ovf_flag, "R1 outputs in reset",
          {cap_flag, ovf_flag, cap_value}, 0);
    rst = 0;
    tick(10);
    check(cap_value == 0 && !cap_flag && !ovf_flag, "R1 after release",
          {cap_flag, ovf_flag, cap_value}, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      mode_v = VEC[v][12:11];
      sync_v = VEC[v][10];
      tsel_v = VEC[v][9:8];
      ntog_v = VEC[v][7:4];
      exp_v  = VEC[v][3:0];
      edge_mode = 2'b00;
      in_sel    = 2'b10;
      tick(5);
      thalf     = (tsel_v == 0) ? 2 : (tsel_v == 1) ? 4 : 20;
      sync_mode = sync_v[0];
      tick(10);
      clr_cap();
      clr_ovf();
      edge_mode = mode_v[1:0];
      tick(5);
      seen = 0;
      for (int k = 0; k < ntog_v; k++) begin
        c0 = tmr_count;
        in_sel[0] = ~in_sel[0];
        tick(40);
        if (cap_flag) begin
          seen++;
          if (sync_v != 0)
            check(int'(cap_value) >= c0 && int'(cap_value) <= int'(tmr_count),
                  "R6 sync value window", cap_value, c0);
          else
            check(int'(cap_value) >= c0 - 12 && int'(cap_value) <= int'(tmr_count),
                  "R5 async value window", cap_value, c0);
          clr_cap();
        end
      end
      check(seen == exp_v, (sync_v != 0) ? "R6 capture count" : "R4 capture count", seen, exp_v);
      check(!ovf_flag, "R10 no overflow when read in time", ovf_flag, 0);
    end

    // R3 source select: pin path and constant ignoring pin
    edge_mode = 2'b00; sync_mode = 0; thalf = 4; cap_pin = 0;
    in_sel = 2'b00; tick(10); clr_cap();
    edge_mode = 2'b01; tick(3);
    cap_pin = 1; tick(10);
    check(cap_flag, "R3 pin via sel 00", cap_flag, 1);
    clr_cap();
    cap_pin = 0; tick(5); in_sel = 2'b01; tick(5); clr_cap();
    cap_pin = 1; tick(10);
    check(cap_flag, "R3 pin via sel 01", cap_flag, 1);
    clr_cap();
    in_sel = 2'b11; tick(5); clr_cap();
    cap_pin = 0; tick(5); cap_pin = 1; tick(5); cap_pin = 0; tick(10);
    check(!cap_flag, "R3 pin ignored with constant", cap_flag, 0);

    // R2 counter steps on rising edges only
    edge_mode = 2'b00; in_sel = 2'b10; sync_mode = 1; thalf = 20;
    stop_tclk();
    c0 = tmr_count;
    tclk = 0; tick(3);
    check(int'(tmr_count) == c0, "R2 no step on falling edge", tmr_count, c0);
    tclk = 1; tick(3);
    repeat (4) tpulse();
    check(int'(tmr_count) == c0 + 5, "R2 five rising edges", tmr_count, c0 + 5);

    // R6 / R7 timer-aligned capture with a short pulse, tclk held
    clr_cap(); clr_ovf();
    edge_mode = 2'b01; tick(3);
    c0 = tmr_count;
    in_sel = 2'b11; tick(1); in_sel = 2'b10;
    tick(30);
    check(!cap_flag, "R6 no capture with tclk stopped", cap_flag, 0);
    tpulse(); tick(5);
    check(!cap_flag, "R6 not after first falling edge", cap_flag, 0);
    tpulse(); tick(5);
    check(!cap_flag, "R6 not after second falling edge", cap_flag, 0);
    tclk = 0; tick(10);
    check(cap_flag, "R7 short pulse still captured", cap_flag, 1);
    check(int'(cap_value) == c0 + 2, "R6 value at third falling edge", cap_value, c0 + 2);
    tclk = 1; tick(3);

    // R8 merge of triggers while pending
    clr_cap();
    edge_mode = 2'b11; tick(3);
    c0 = tmr_count;
    in_sel = 2'b11; tick(1); in_sel = 2'b10; tick(1); in_sel = 2'b11;
    tick(20);
    repeat (3) tpulse();
    tick(5);
    check(cap_flag && int'(cap_value) == c0 + 2, "R8 merged capture value", cap_value, c0 + 2);
    clr_cap();
    repeat (4) tpulse();
    tick(5);
    check(!cap_flag, "R8 no extra capture from merged triggers", cap_flag, 0);

    // R10 overflow, then R9 / R10 clears
    in_sel = 2'b10; tick(3);
    repeat (3) tpulse();
    tick(5);
    check(cap_flag && !ovf_flag, "R9 flag set by capture", {cap_flag, ovf_flag}, 2);
    in_sel = 2'b11; tick(3);
    repeat (3) tpulse();
    tick(5);
    check(ovf_flag, "R10 overflow on unread capture", ovf_flag, 1);
    clr_ovf(); tick(2);
    check(!ovf_flag && cap_flag, "R10 overflow clear", {cap_flag, ovf_flag}, 2);
    clr_cap(); tick(2);
    check(!cap_flag, "R9 capture flag clear", cap_flag, 0);

    trun = 1;
    tick(10);
    finish_run();
  end
endmodule